// File: doc/BRIEF.md
# Shared Buffer RAM Access Arbiter

This block decides, one clock at a time, who may use a buffer memory shared between a host processor and a set of serial-bus protocol controllers. The processor can ask for the shared RAM on behalf of one controller's node, or it can ask for that node's register space. Each controller node can ask for the RAM for itself. Only one requester holds a grant at any moment, and each grant lasts a fixed number of clocks.

While the processor holds a RAM grant, the block drives the RAM chip select, the read or write strobe of the selected node, and that node's address and data buffer enables. While a controller holds the grant, the block releases the chip select and that node's strobes by dropping their output enables. The pin driver outside this block turns those enables into high impedance. On the last clock of a controller grant, the block pulls that node's active-low transfer acknowledge low so the controller can end its cycle. A processor register grant asserts that node's processor-enable, register select and direction lines instead. A static mode input states whether the shared RAM is internal. In that case the external RAM pins are held inactive, but arbitration still takes place.

Requests are levels. A requester holds its request until it sees its acknowledge (controllers) or the done pulse (processor), then lowers it. The processor request fields are captured on the clock at which the grant is taken.

Top module: `shram_arbiter`

## Requirements
- R1: Under synchronous active-high reset and whenever no grant is active, all active-low outputs are high, the buffer enables are 0, cpu_done is 0, and every output enable (ram_cs_oe, strb_oe) is 1.
- R2: When the processor and one or more nodes request on the same clock while no grant is active, the processor is granted first.
- R3: A grant is never pre-empted. A request raised while another grant is active waits until that grant ends, and the arbiter is idle for one clock after each grant before it grants again.
- R4: When several nodes request on the same clock with no processor request, the node with the lowest index wins.
- R5: A grant starts on the clock after the winning request is sampled in the idle state and lasts exactly GRANT_CYCLES clocks.
- R6: During a processor RAM grant with ram_internal=0, ram_cs_n is 0. Selected node k has strb_wr_n[k]=0 when cpu_wr=1, or strb_rd_n[k]=0 when cpu_wr=0, and addr_buf_en[k]=data_buf_en[k]=1. All other nodes keep their strobes high and their enables 0.
- R7: During a processor RAM grant with ram_internal=1, ram_cs_n, all strobes and all buffer enables stay inactive.
- R8: During a grant to node k, ram_cs_oe=0 and strb_oe[k]=0. All other strb_oe bits stay 1.
- R9: xfer_ack_n[k] is 0 only on the last clock of a grant to node k. cpu_done is 1 only on the last clock of a processor grant.
- R10: During a processor register grant for node k, reg_cpu_en_n[k]=0, reg_cs_n[k]=0 and reg_rw_n[k]=!cpu_wr (0 means write). The RAM chip select and strobes stay inactive. Register requests contend with node RAM requests under R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ram_internal | input | 1 | 1: shared RAM is internal, 0: external |
| cpu_req | input | 1 | Processor access request (level) |
| cpu_is_reg | input | 1 | 1: register access, 0: RAM access |
| cpu_wr | input | 1 | 1: write, 0: read |
| cpu_node | input | IDX_W | Node targeted by the processor |
| node_req | input | N_NODE | Per-node controller RAM request (level) |
| ram_cs_n | output | 1 | External RAM chip select, active low |
| ram_cs_oe | output | 1 | Output enable of ram_cs_n |
| strb_rd_n | output | N_NODE | Per-node read strobe, active low |
| strb_wr_n | output | N_NODE | Per-node write strobe, active low |
| strb_oe | output | N_NODE | Per-node strobe output enable |
| addr_buf_en | output | N_NODE | Per-node address buffer enable |
| data_buf_en | output | N_NODE | Per-node data buffer enable |
| xfer_ack_n | output | N_NODE | Per-node transfer acknowledge, active low |
| reg_cpu_en_n | output | N_NODE | Per-node processor enable, active low |
| reg_cs_n | output | N_NODE | Per-node register select, active low |
| reg_rw_n | output | N_NODE | Per-node register direction, 1 read / 0 write |
| cpu_done | output | 1 | Last clock of a processor grant |

## Verification
The bench builds the block with N_NODE=3 and GRANT_CYCLES=2. Three nodes make the lowest-index priority a chain rather than a single pairwise choice, so a three-way tie and a tie between the two upper nodes can each be tested. Two-clock grants keep every scenario short, and they still separate the first grant clock from the last, which is where the acknowledge and done pulses must appear.

// File: rtl/shram_pkg.sv
package shram_pkg;

    localparam int NODE_IDX_W = 4;

    typedef enum logic [1:0] {
        OWN_IDLE    = 2'd0,
        OWN_CPU_RAM = 2'd1,
        OWN_CPU_REG = 2'd2,
        OWN_NODE    = 2'd3
    } own_kind_e;

    typedef struct packed {
        own_kind_e              kind;
        logic [NODE_IDX_W-1:0]  idx;
        logic                   wr;
    } grant_t;

    function automatic grant_t idle_grant();
        grant_t g;
        g.kind = OWN_IDLE;
        g.idx  = '0;
        g.wr   = 1'b0;
        return g;
    endfunction

    function automatic logic is_cpu(grant_t g);
        return (g.kind == OWN_CPU_RAM) || (g.kind == OWN_CPU_REG);
    endfunction

endpackage

// File: rtl/shram_pick.sv
module shram_pick
    import shram_pkg::*;
#(
    parameter int N_NODE = 2,
    parameter int IDX_W  = 1
) (
    input  logic              cpu_req,
    input  logic              cpu_is_reg,
    input  logic              cpu_wr,
    input  logic [IDX_W-1:0]  cpu_node,
    input  logic [N_NODE-1:0] node_req,
    output grant_t            pick,
    output logic              any_req
);
    always_comb begin
        pick    = idle_grant();
        any_req = 1'b0;
        for (int k = N_NODE - 1; k >= 0; k--) begin
            if (node_req[k]) begin
                pick.kind = OWN_NODE;
                pick.idx  = NODE_IDX_W'(k);
                pick.wr   = 1'b0;
                any_req   = 1'b1;
            end
        end
        if (cpu_req) begin
            pick.kind = cpu_is_reg ? OWN_CPU_REG : OWN_CPU_RAM;
            pick.idx  = NODE_IDX_W'(cpu_node);
            pick.wr   = cpu_wr;
            any_req   = 1'b1;
        end
    end
endmodule

// File: rtl/shram_timer.sv
module shram_timer #(
    parameter int GRANT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic last
);
    localparam int CNT_W = (GRANT_CYCLES > 1) ? $clog2(GRANT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GRANT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (active && cnt != LAST_CNT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = active && (cnt == LAST_CNT);
endmodule

// File: rtl/shram_drive.sv
module shram_drive
    import shram_pkg::*;
#(
    parameter int N_NODE = 2
) (
    input  grant_t            cur,
    input  logic              last,
    input  logic              ram_internal,
    output logic              ram_cs_n,
    output logic              ram_cs_oe,
    output logic [N_NODE-1:0] strb_rd_n,
    output logic [N_NODE-1:0] strb_wr_n,
    output logic [N_NODE-1:0] strb_oe,
    output logic [N_NODE-1:0] addr_buf_en,
    output logic [N_NODE-1:0] data_buf_en,
    output logic [N_NODE-1:0] xfer_ack_n,
    output logic [N_NODE-1:0] reg_cpu_en_n,
    output logic [N_NODE-1:0] reg_cs_n,
    output logic [N_NODE-1:0] reg_rw_n,
    output logic              cpu_done
);
    logic ext_ram_cycle;

    assign ext_ram_cycle = (cur.kind == OWN_CPU_RAM) && !ram_internal;
    assign ram_cs_n      = !ext_ram_cycle;
    assign ram_cs_oe     = (cur.kind != OWN_NODE);
    assign cpu_done      = is_cpu(cur) && last;

    for (genvar k = 0; k < N_NODE; k++) begin : g_node
        logic hit, ram_k, reg_k, node_k;
        assign hit    = (cur.idx == NODE_IDX_W'(k));
        assign ram_k  = hit && ext_ram_cycle;
        assign reg_k  = hit && (cur.kind == OWN_CPU_REG);
        assign node_k = hit && (cur.kind == OWN_NODE);

        assign strb_rd_n[k]    = !(ram_k && !cur.wr);
        assign strb_wr_n[k]    = !(ram_k &&  cur.wr);
        assign addr_buf_en[k]  = ram_k;
        assign data_buf_en[k]  = ram_k;
        assign strb_oe[k]      = !node_k;
        assign xfer_ack_n[k]   = !(node_k && last);
        assign reg_cpu_en_n[k] = !reg_k;
        assign reg_cs_n[k]     = !reg_k;
        assign reg_rw_n[k]     = !(reg_k && cur.wr);
    end
endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter
    import shram_pkg::*;
#(
    parameter int N_NODE       = 2,
    parameter int GRANT_CYCLES = 3,
    localparam int IDX_W       = (N_NODE > 1) ? $clog2(N_NODE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ram_internal,
    input  logic              cpu_req,
    input  logic              cpu_is_reg,
    input  logic              cpu_wr,
    input  logic [IDX_W-1:0]  cpu_node,
    input  logic [N_NODE-1:0] node_req,
    output logic              ram_cs_n,
    output logic              ram_cs_oe,
    output logic [N_NODE-1:0] strb_rd_n,
    output logic [N_NODE-1:0] strb_wr_n,
    output logic [N_NODE-1:0] strb_oe,
    output logic [N_NODE-1:0] addr_buf_en,
    output logic [N_NODE-1:0] data_buf_en,
    output logic [N_NODE-1:0] xfer_ack_n,
    output logic [N_NODE-1:0] reg_cpu_en_n,
    output logic [N_NODE-1:0] reg_cs_n,
    output logic [N_NODE-1:0] reg_rw_n,
    output logic              cpu_done
);
    grant_t cur, pick;
    logic   any_req, grant_busy, grant_start, grant_last, grant_cpu;

    shram_pick #(.N_NODE(N_NODE), .IDX_W(IDX_W)) i_pick (
        .cpu_req    (cpu_req),
        .cpu_is_reg (cpu_is_reg),
        .cpu_wr     (cpu_wr),
        .cpu_node   (cpu_node),
        .node_req   (node_req),
        .pick       (pick),
        .any_req    (any_req)
    );

    assign grant_busy  = (cur.kind != OWN_IDLE);
    assign grant_start = !grant_busy && any_req;
    assign grant_cpu   = is_cpu(cur);

    shram_timer #(.GRANT_CYCLES(GRANT_CYCLES)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (grant_start),
        .active (grant_busy),
        .last   (grant_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= idle_grant();
        end else if (grant_start) begin
            cur <= pick;
        end else if (grant_last) begin
            cur <= idle_grant();
        end
    end

    shram_drive #(.N_NODE(N_NODE)) i_drive (
        .cur          (cur),
        .last         (grant_last),
        .ram_internal (ram_internal),
        .ram_cs_n     (ram_cs_n),
        .ram_cs_oe    (ram_cs_oe),
        .strb_rd_n    (strb_rd_n),
        .strb_wr_n    (strb_wr_n),
        .strb_oe      (strb_oe),
        .addr_buf_en  (addr_buf_en),
        .data_buf_en  (data_buf_en),
        .xfer_ack_n   (xfer_ack_n),
        .reg_cpu_en_n (reg_cpu_en_n),
        .reg_cs_n     (reg_cs_n),
        .reg_rw_n     (reg_rw_n),
        .cpu_done     (cpu_done)
    );
endmodule

// File: rtl/shram_arbiter_chk.sv
module shram_arbiter_chk #(
    parameter int N_NODE = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              ram_cs_n,
    input logic              ram_cs_oe,
    input logic [N_NODE-1:0] strb_rd_n,
    input logic [N_NODE-1:0] strb_wr_n,
    input logic [N_NODE-1:0] strb_oe,
    input logic [N_NODE-1:0] xfer_ack_n,
    input logic [N_NODE-1:0] reg_cs_n,
    input logic              cpu_done,
    input logic              grant_busy,
    input logic              grant_last,
    input logic              grant_cpu
);
    AST_CPU_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!grant_busy && cpu_req) |=> grant_cpu); // R2

    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
        grant_last |=> !grant_busy); // R3

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (grant_busy && !grant_last) |=> grant_busy); // R5

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        ((~strb_rd_n) & (~strb_wr_n)) == '0); // R6

    AST_NODE_RELEASE_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~strb_oe)); // R8

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !ram_cs_oe |-> ($countones(~strb_oe) == 1)); // R8

    AST_ACK_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
        ((~xfer_ack_n) & strb_oe) == '0); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done); // R9

    AST_REG_NOT_RAM: assert property (@(posedge clk) disable iff (rst)
        (reg_cs_n != '1) |-> ram_cs_n); // R10
endmodule

bind shram_arbiter shram_arbiter_chk #(.N_NODE(N_NODE)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .ram_cs_n   (ram_cs_n),
    .ram_cs_oe  (ram_cs_oe),
    .strb_rd_n  (strb_rd_n),
    .strb_wr_n  (strb_wr_n),
    .strb_oe    (strb_oe),
    .xfer_ack_n (xfer_ack_n),
    .reg_cs_n   (reg_cs_n),
    .cpu_done   (cpu_done),
    .grant_busy (grant_busy),
    .grant_last (grant_last),
    .grant_cpu  (grant_cpu)
);

// File: tb/test_shram_arbiter.sv
module test_shram_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NN = 3;
    localparam int GC = 2;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ram_internal = 1'b0;
    logic          cpu_req = 1'b0, cpu_is_reg = 1'b0, cpu_wr = 1'b0;
    logic [IW-1:0] cpu_node = '0;
    logic [NN-1:0] node_req = '0;
    logic          ram_cs_n, ram_cs_oe, cpu_done;
    logic [NN-1:0] strb_rd_n, strb_wr_n, strb_oe, addr_buf_en, data_buf_en;
    logic [NN-1:0] xfer_ack_n, reg_cpu_en_n, reg_cs_n, reg_rw_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shram_arbiter #(.N_NODE(NN), .GRANT_CYCLES(GC)) i_shram_arbiter (
        .clk(clk), .rst(rst), .ram_internal(ram_internal),
        .cpu_req(cpu_req), .cpu_is_reg(cpu_is_reg), .cpu_wr(cpu_wr),
        .cpu_node(cpu_node), .node_req(node_req),
        .ram_cs_n(ram_cs_n), .ram_cs_oe(ram_cs_oe),
        .strb_rd_n(strb_rd_n), .strb_wr_n(strb_wr_n), .strb_oe(strb_oe),
        .addr_buf_en(addr_buf_en), .data_buf_en(data_buf_en),
        .xfer_ack_n(xfer_ack_n), .reg_cpu_en_n(reg_cpu_en_n),
        .reg_cs_n(reg_cs_n), .reg_rw_n(reg_rw_n), .cpu_done(cpu_done)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state: kind 0 idle, 1 cpu RAM, 2 cpu register, 3 node
    int m_busy = 0, m_kind = 0, m_idx = 0, m_wr = 0, m_cnt = 0;
    int order_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_kind = 0; m_cnt = 0;
        end else if (m_busy == 0) begin
            if (cpu_req) begin
                m_busy = 1; m_kind = cpu_is_reg ? 2 : 1;
                m_idx = int'(cpu_node); m_wr = int'(cpu_wr); m_cnt = 0;
            end else begin
                for (int k = NN - 1; k >= 0; k--) begin
                    if (node_req[k]) begin
                        m_busy = 1; m_kind = 3; m_idx = k; m_cnt = 0;
                    end
                end
            end
        end else if (m_cnt == GC - 1) begin
            m_busy = 0; m_kind = 0;
        end else begin
            m_cnt++;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        logic          last, e_cs_n, e_cs_oe, e_done;
        logic [NN-1:0] e_rd, e_wr, e_oe, e_en, e_ack, e_ren, e_rcs, e_rrw;
        string         tag;
        last = (m_busy != 0) && (m_cnt == GC - 1);
        e_cs_n  = !(m_kind == 1 && !ram_internal);
        e_cs_oe = (m_kind != 3);
        e_done  = (m_kind == 1 || m_kind == 2) && last;
        for (int k = 0; k < NN; k++) begin
            e_rd[k]  = !(m_kind == 1 && !ram_internal && m_idx == k && m_wr == 0);
            e_wr[k]  = !(m_kind == 1 && !ram_internal && m_idx == k && m_wr == 1);
            e_en[k]  =  (m_kind == 1 && !ram_internal && m_idx == k);
            e_oe[k]  = !(m_kind == 3 && m_idx == k);
            e_ack[k] = !(m_kind == 3 && m_idx == k && last);
            e_ren[k] = !(m_kind == 2 && m_idx == k);
            e_rcs[k] = !(m_kind == 2 && m_idx == k);
            e_rrw[k] = !(m_kind == 2 && m_idx == k && m_wr == 1);
        end
        case (m_kind)
            1: tag = ram_internal ? "R7" : "R6";
            2: tag = "R10";
            3: tag = "R8";
            default: tag = "R1";
        endcase
        chk(tag, "ram_cs_n", 32'(ram_cs_n), 32'(e_cs_n));
        chk("R8", "ram_cs_oe", 32'(ram_cs_oe), 32'(e_cs_oe));
        chk(tag, "strb_rd_n", 32'(strb_rd_n), 32'(e_rd));
        chk(tag, "strb_wr_n", 32'(strb_wr_n), 32'(e_wr));
        chk(tag, "addr_buf_en", 32'(addr_buf_en), 32'(e_en));
        chk(tag, "data_buf_en", 32'(data_buf_en), 32'(e_en));
        chk("R8", "strb_oe", 32'(strb_oe), 32'(e_oe));
        chk("R9", "xfer_ack_n", 32'(xfer_ack_n), 32'(e_ack));
        chk("R9", "cpu_done", 32'(cpu_done), 32'(e_done));
        chk("R10", "reg_cpu_en_n", 32'(reg_cpu_en_n), 32'(e_ren));
        chk("R10", "reg_cs_n", 32'(reg_cs_n), 32'(e_rcs));
        chk("R10", "reg_rw_n", 32'(reg_rw_n), 32'(e_rrw));
    endtask

    // one clock: compare at the falling edge, then requesters react to their acknowledge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            for (int k = 0; k < NN; k++) begin
                if (xfer_ack_n[k] === 1'b0) begin
                    node_req[k] = 1'b0;
                    order_q.push_back(k);
                end
            end
            if (cpu_done === 1'b1) begin
                cpu_req = 1'b0;
                order_q.push_back(100);
            end
        end
    endtask

    task automatic cpu_go(input logic is_reg, input logic wr, input int node);
        cpu_is_reg = is_reg; cpu_wr = wr; cpu_node = IW'(node); cpu_req = 1'b1;
    endtask

    task automatic check_order(input string tag, input int a, input int b, input int c);
        int exp_q[$];
        exp_q = {a, b};
        if (c >= 0) exp_q.push_back(c);
        n_cmp++;
        if (order_q != exp_q) begin
            n_bad++;
            $display("FAIL %s grant order: actual %p expected %p", tag, order_q, exp_q);
        end
        order_q = {};
    endtask

    task automatic run();
        step(3);                      // R1 reset state compared each clock
        rst = 1'b0;
        step(2);
        // R6: external RAM read and write by the processor
        cpu_go(1'b0, 1'b0, 0); step(5);
        cpu_go(1'b0, 1'b1, 2); step(5);
        // R8 R9: single node grant
        node_req[1] = 1'b1; step(5);
        order_q = {};
        // R2: processor and node collide on one clock
        cpu_go(1'b0, 1'b1, 1); node_req[0] = 1'b1; step(9);
        check_order("R2", 100, 0, -1);
        // R4: three-way node tie, then tie of the upper two
        node_req = 3'b111; step(12);
        check_order("R4", 0, 1, 2);
        node_req = 3'b110; step(9);
        check_order("R4", 1, 2, -1);
        // R3: node 2 holds; later processor and node 0 requests wait
        node_req[2] = 1'b1; step(1);
        cpu_go(1'b0, 1'b0, 1); step(1);
        node_req[0] = 1'b1; step(10);
        check_order("R3", 2, 100, 0);
        // R10: register write colliding with node 1 RAM request, then register read
        cpu_go(1'b1, 1'b1, 1); node_req[1] = 1'b1; step(9);
        check_order("R10", 100, 1, -1);
        cpu_go(1'b1, 1'b0, 2); step(5);
        // R7: internal RAM mode, processor RAM write and a node grant
        ram_internal = 1'b1; step(1);
        cpu_go(1'b0, 1'b1, 0); step(5);
        node_req[2] = 1'b1; step(5);
        ram_internal = 1'b0; step(2);
        // R1: reset in the middle of a grant returns to idle outputs
        node_req[0] = 1'b1; step(2);
        rst = 1'b1; node_req = '0; step(2);
        rst = 1'b0; step(3);
    endtask

    initial begin
        bit wd = 1'b0;
        fork
            run();
            begin repeat (20000) @(posedge clk); wd = 1'b1; end
        join_any
        if (wd) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule